// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

This block is a presettable synchronous counter stage. A parameter sets it to count in decimal steps (modulo 10) or in plain binary steps (modulo 16). All state bits change together on the rising clock edge. A low level on the load pin copies the parallel data word into the state at the next edge. The state advances only when both active-low count enables are low, and the direction pin chooses between counting up and counting down.

The active-low carry output shows that the stage has reached its terminal count for the current direction, which is the top value when counting up and zero when counting down. It can only go low while the T enable is low. Identical stages are chained by tying every stage's P enable, clock, load and direction pins in common, and by feeding each stage's carry into the next stage's T enable. The result is a wider synchronous counter that needs no extra gating.

Top module: `updn_cascade_counter`

## Requirements
- R1: While `rst_n` is low, `q` is cleared to 0.
- R2: When `load_n` is low at a rising edge, `q` takes `din` at that edge, whatever the enables and direction are. Load has priority over counting.
- R3: When `load_n` is high and either `en_p_n` or `en_t_n` is high at a rising edge, `q` keeps its value.
- R4: When `load_n` is high, both enables are low and `up` is 1, `q` steps up by one at the edge. From the top value (9 in decimal mode, 15 in binary mode) it wraps to 0.
- R5: When `load_n` is high, both enables are low and `up` is 0, `q` steps down by one at the edge. From 0 it wraps to the top value.
- R6: `carry_n` is 0 exactly when `en_t_n` is 0 and either `up` is 1 with `q` at the top value, or `up` is 0 with `q` equal to 0. The carry is combinational and follows `up` and `en_t_n` without waiting for a clock.
- R7: `en_p_n` has no effect on `carry_n`.
- R8: In decimal mode, a loaded value from 10 to 15 becomes 0 after one up count and 9 after one down count. While the state holds such a value, `carry_n` stays high.
- R9: In binary mode, the state steps through all sixteen values 0 to 15 (for example 12 steps up to 13).
- R10: Two decimal stages with the low stage's `carry_n` driving the high stage's `en_t_n` count as one two-digit number, up and down, wrapping between 99 and 00.
- R11: Changes on `load_n`, `din`, the enables or `up` between rising edges leave `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low initialisation clear |
| din | input | WIDTH | Parallel data word for loading |
| load_n | input | 1 | Active-low synchronous load |
| en_p_n | input | 1 | Active-low count enable P (affects counting only) |
| en_t_n | input | 1 | Active-low count enable T (also gates the carry) |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| q | output | WIDTH | Counter state |
| carry_n | output | 1 | Active-low terminal-count carry |

## Verification
The bench builds three stages. Two use `DECADE=1` and are chained into a two-digit decimal counter. The third uses `DECADE=0` and runs beside them on the same controls. The decimal pair brings within reach the carry passing from one stage to the next in both directions, the 99/00 wrap, and the recovery of illegal loaded values. The binary stage shows counting through 10 to 15, and its own wrap from 15 to 0 and from 0 to 15, under exactly the same stimulus.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2
  } mode_e;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/updn_mode_dec.sv
module updn_mode_dec
  import updn_pkg::*;
(
  input  logic  load_n,
  input  logic  en_p_n,
  input  logic  en_t_n,
  output mode_e mode
);
  always_comb begin
    if (!load_n)                mode = MODE_LOAD;
    else if (!en_p_n && !en_t_n) mode = MODE_COUNT;
    else                        mode = MODE_HOLD;
  end
endmodule

// File: rtl/updn_step.sv
module updn_step
  import updn_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] TOP  = WIDTH'(DECADE ? 9 : (2**WIDTH) - 1);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  generate
    if (DECADE) begin : g_dec
      // Out-of-range codes collapse to a legal value in a single step.
      always_comb begin
        if (dir == DIR_UP) nxt = (cur >= TOP) ? ZERO : cur + ONE;
        else               nxt = (cur == ZERO || cur > TOP) ? TOP : cur - ONE;
      end
    end else begin : g_bin
      always_comb begin
        if (dir == DIR_UP) nxt = cur + ONE;
        else               nxt = cur - ONE;
      end
    end
  endgenerate
endmodule

// File: rtl/updn_term.sv
module updn_term
  import updn_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  input  logic             en_t_n,
  output logic             carry_n
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(DECADE ? 9 : (2**WIDTH) - 1);

  logic at_term;

  always_comb begin
    if (dir == DIR_UP) at_term = (cur == TOP);
    else               at_term = (cur == '0);
  end

  assign carry_n = ~(~en_t_n & at_term);
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
  import updn_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             load_n,
  input  logic             en_p_n,
  input  logic             en_t_n,
  input  logic             up,
  output logic [WIDTH-1:0] q,
  output logic             carry_n
);
  mode_e            mode;
  dir_e             dir;
  logic [WIDTH-1:0] step_val;
  logic [WIDTH-1:0] state_q;

  assign dir = up ? DIR_UP : DIR_DOWN;

  updn_mode_dec u_mode (
    .load_n (load_n),
    .en_p_n (en_p_n),
    .en_t_n (en_t_n),
    .mode   (mode)
  );

  updn_step #(.WIDTH(WIDTH), .DECADE(DECADE)) u_step (
    .cur (state_q),
    .dir (dir),
    .nxt (step_val)
  );

  updn_term #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
    .cur     (state_q),
    .dir     (dir),
    .en_t_n  (en_t_n),
    .carry_n (carry_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else begin
      unique case (mode)
        MODE_LOAD:  state_q <= din;
        MODE_COUNT: state_q <= step_val;
        default:    state_q <= state_q;
      endcase
    end
  end

  assign q = state_q;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] din,
  input logic             load_n,
  input logic             en_p_n,
  input logic             en_t_n,
  input logic             up,
  input logic [WIDTH-1:0] q,
  input logic             carry_n
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(DECADE ? 9 : (2**WIDTH) - 1);

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(din)); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && (en_p_n || en_t_n)) |=> $stable(q)); // R3

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !en_p_n && !en_t_n && up && q == TOP) |=> q == '0); // R4

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !en_p_n && !en_t_n && !up && q == '0) |=> q == TOP); // R5

  AST_CARRY_NEEDS_T: assert property (@(posedge clk) disable iff (!rst_n)
    en_t_n |-> carry_n); // R6

  AST_LEGAL_STAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && q <= TOP) |=> q <= TOP); // R8
endmodule

bind updn_cascade_counter updn_counter_chk #(.WIDTH(WIDTH), .DECADE(DECADE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .din     (din),
  .load_n  (load_n),
  .en_p_n  (en_p_n),
  .en_t_n  (en_t_n),
  .up      (up),
  .q       (q),
  .carry_n (carry_n)
);

// File: tb/updn_cascade_counter_bench.sv
`timescale 1ns/1ps
module updn_cascade_counter_bench;
  typedef struct packed {
    logic [3:0] lo;
    logic [3:0] hi;
    logic [3:0] bn;
    logic       c_lo;
    logic       c_hi;
    logic       c_bn;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] d_lo = '0, d_hi = '0;
  logic load_n = 1'b1, p_n = 1'b1, t_n = 1'b1, up = 1'b1;
  logic [3:0] q_lo, q_hi, q_bn;
  logic c_lo, c_hi, c_bn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  exp_t exp_q[$];
  string req_q[$];
  logic [3:0] m_lo = '0, m_hi = '0, m_bn = '0;

  always #10 clk = ~clk;

  updn_cascade_counter #(.WIDTH(4), .DECADE(1'b1)) u_updn_cascade_counter (
    .clk(clk), .rst_n(rst_n), .din(d_lo), .load_n(load_n), .en_p_n(p_n),
    .en_t_n(t_n), .up(up), .q(q_lo), .carry_n(c_lo));

  updn_cascade_counter #(.WIDTH(4), .DECADE(1'b1)) u_hi (
    .clk(clk), .rst_n(rst_n), .din(d_hi), .load_n(load_n), .en_p_n(p_n),
    .en_t_n(c_lo), .up(up), .q(q_hi), .carry_n(c_hi));

  updn_cascade_counter #(.WIDTH(4), .DECADE(1'b0)) u_bin (
    .clk(clk), .rst_n(rst_n), .din(d_lo), .load_n(load_n), .en_p_n(p_n),
    .en_t_n(t_n), .up(up), .q(q_bn), .carry_n(c_bn));

  function automatic logic [3:0] f_next(logic [3:0] c, bit dec, bit ld_n,
                                        logic [3:0] d, bit p, bit t, bit u);
    logic [3:0] top;
    top = dec ? 4'd9 : 4'd15;
    if (!ld_n) return d;
    if (p || t) return c;
    if (u) return (c >= top) ? 4'd0 : c + 4'd1;
    return (c == 4'd0 || c > top) ? top : c - 4'd1;
  endfunction

  function automatic logic f_carry(logic [3:0] c, bit dec, bit t, bit u);
    logic [3:0] top;
    top = dec ? 4'd9 : 4'd15;
    return ~(~t & (u ? (c == top) : (c == 4'd0)));
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: apply one cycle of controls and queue the expected post-edge view.
  task automatic drive(bit ld_n, logic [3:0] dl, logic [3:0] dh, bit p, bit t,
                       bit u, string req);
    exp_t e;
    logic cl_pre;
    @(negedge clk);
    load_n = ld_n; d_lo = dl; d_hi = dh; p_n = p; t_n = t; up = u;
    cl_pre = f_carry(m_lo, 1'b1, t, u);
    m_hi = f_next(m_hi, 1'b1, ld_n, dh, p, cl_pre, u);
    m_lo = f_next(m_lo, 1'b1, ld_n, dl, p, t, u);
    m_bn = f_next(m_bn, 1'b0, ld_n, dl, p, t, u);
    e.lo = m_lo; e.hi = m_hi; e.bn = m_bn;
    e.c_lo = f_carry(m_lo, 1'b1, t, u);
    e.c_hi = f_carry(m_hi, 1'b1, e.c_lo, u);
    e.c_bn = f_carry(m_bn, 1'b0, t, u);
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  // Monitor: one pop per rising edge, sampled just after the edge settles.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(r, {1'b0, q_lo, q_hi, q_bn, c_lo, c_hi, c_bn},
               {1'b0, e.lo, e.hi, e.bn, e.c_lo, e.c_hi, e.c_bn});
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: cleared state while reset is held
    check("R1", {4'h0, q_lo, q_hi, q_bn}, 16'h0000);
    rst_n = 1'b1;
    // R2: load wins over active enables
    drive(1'b0, 4'd8, 4'd9, 1'b0, 1'b0, 1'b1, "R2");
    // R4 R9 R10: 98 -> 99 -> 00 -> 01, binary 8 -> 9 -> 10 -> 11
    drive(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, "R4");
    drive(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, "R10");
    drive(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, "R9");
    // R3: hold via P, then via T
    drive(1'b1, 4'd5, 4'd5, 1'b1, 1'b0, 1'b1, "R3");
    drive(1'b1, 4'd5, 4'd5, 1'b0, 1'b1, 1'b1, "R3");
    // R5 R10: count down through 00 into 99 and beyond
    for (int i = 0; i < 25; i++) drive(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, "R5");
    // R7: at 9 with P high and T low the carry must still be active
    drive(1'b0, 4'd9, 4'd3, 1'b0, 1'b0, 1'b1, "R2");
    drive(1'b1, 4'd0, 4'd0, 1'b1, 1'b0, 1'b1, "R7");
    drive(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, "R10");
    // R6: direction flip moves the carry without an edge changing the state
    drive(1'b1, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0, "R6");
    drive(1'b1, 4'd0, 4'd0, 1'b1, 1'b1, 1'b0, "R6");
    // R8: illegal decimal codes; binary stage sees 12 -> 13 (R9)
    drive(1'b0, 4'd12, 4'd0, 1'b1, 1'b1, 1'b1, "R8");
    drive(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, "R8");
    drive(1'b0, 4'd15, 4'd0, 1'b1, 1'b1, 1'b1, "R8");
    drive(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, "R8");
    drive(1'b0, 4'd13, 4'd0, 1'b1, 1'b0, 1'b1, "R8");
    // R9: binary wrap 15 -> 0 and 0 -> 15
    drive(1'b0, 4'd15, 4'd0, 1'b1, 1'b1, 1'b1, "R9");
    drive(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, "R9");
    drive(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, "R9");
    // R11: controls toggle in the low phase, then revert before the edge
    @(negedge clk);
    #1;
    begin
      logic [3:0] snap_lo, snap_bn;
      snap_lo = q_lo; snap_bn = q_bn;
      load_n = 1'b0; d_lo = 4'd6; p_n = 1'b0; t_n = 1'b0; up = 1'b0;
      #3;
      check("R11", {8'h00, q_lo, q_bn}, {8'h00, snap_lo, snap_bn});
      load_n = 1'b1; p_n = 1'b1; t_n = 1'b1;
    end
    drive(1'b1, 4'd0, 4'd0, 1'b1, 1'b1, 1'b1, "R11");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule